// File: doc/BRIEF.md
# Sequential Selective-Call Tone Decoder

This block recognises a five-digit selective-call code sent over a radio channel as a chain of audio tones. An external tone filter is tuned by a divider code from the block. It reports through an active-low detect line when the tone it is tuned to is present. The decoder starts on the first digit of its stored call number. It steps to the next digit each time the current tone ends. After the fifth tone ends it accepts the call.

Two codes are stored as parameters: the station's own number and a group number for all-calls. While idle on the first digit, the decoder tunes the filter to the first digit of each code in turn. A tone that starts fixes which code is followed for the rest of the call. If the next tone does not begin within a set window, the decoder returns to the first digit.

On acceptance the decoder pulses a notify line for a serial link, closes a relay output and starts an alarm. An individual call sounds the alarm for a fixed number of slow ticks. An all-call keeps the alarm on until the call-reset input is raised. A test input forces the alarm and the relay on.

Top module: `selcall_decoder`

## Requirements
- R1: After reset, `div_o` carries the divider of the individual code's first digit, and `notify_o`, `relay_o`, `alarm_o` and `all_call_o` are low.
- R2: The cycle after a sampled low-to-high change of `tone_n` on digit k (k below 4), `div_o` carries the divider of digit k+1 of the code being followed.
- R3: When the fifth tone ends, `notify_o` is high for exactly one cycle, two clocks after the rising `tone_n` is sampled, together with `relay_o` and `alarm_o`, and the sequencer returns to digit 0.
- R4: After an individual call, `alarm_o` falls after ALARM_TICKS ticks of the slow tick. `relay_o` stays high.
- R5: After a group-code call, `all_call_o` and `alarm_o` stay high until `call_reset` is sampled high.
- R6: A sampled `call_reset` clears `relay_o`, `alarm_o` and `all_call_o` on the next clock. If a call completes in the same cycle, the completion wins and the outputs stay set.
- R7: While `test_i` is sampled high, `relay_o` and `alarm_o` are high on the next clock. `notify_o` stays low.
- R8: If no tone starts within TIMEOUT_CYC cycles after a tone ends on digits 1 to 4, the sequencer returns to digit 0 on the individual code.
- R9: While idle on digit 0, `div_o` alternates between the first-digit dividers of the individual and the group code every DWELL_CYC cycles. A tone that starts holds the current choice.
- R10: The divider for digit d is DIV_BASE minus d times DIV_STEP, truncated to DIVW bits. Digits are DIGW-bit fields, and digit 0 is the most significant field of the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_n | input | 1 | Tone present when low, from the external filter |
| call_reset | input | 1 | Clears relay, alarm and all-call flag |
| test_i | input | 1 | Forces alarm and relay on |
| div_o | output | DIVW | Divider code for the expected tone |
| notify_o | output | 1 | One-cycle pulse for the serial link on acceptance |
| relay_o | output | 1 | Call relay drive |
| alarm_o | output | 1 | Alarm tone enable |
| all_call_o | output | 1 | Last accepted call was a group call |

## Verification
A call completion and a `call_reset` can land in the same cycle. In that cycle the alarm stage would both set and clear its state. The bench provokes this by raising `call_reset` on the clock that the final tone's end reaches the alarm stage, while a group alarm is already latched. It expects the relay and alarm to stay set with the all-call flag cleared. A behavioural model checks every output on every clock, so the timed alarm expiry, the first-digit alternation and the gap timeout are also compared cycle by cycle.

// File: rtl/selcall_pkg.sv
package selcall_pkg;
  typedef enum logic {
    TRK_IND = 1'b0,
    TRK_GRP = 1'b1
  } track_e;
endpackage

// File: rtl/selcall_tick.sv
module selcall_tick #(
  parameter int TICK_CYC = 200_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(TICK_CYC - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/selcall_seq.sv
module selcall_seq
  import selcall_pkg::*;
#(
  parameter int DIGITS      = 5,
  parameter int DIGW        = 4,
  parameter int DIVW        = 8,
  parameter logic [DIGITS*DIGW-1:0] IND_CODE = 20'h27183,
  parameter logic [DIGITS*DIGW-1:0] GRP_CODE = 20'h99999,
  parameter int DIV_BASE    = 200,
  parameter int DIV_STEP    = 7,
  parameter int TIMEOUT_CYC = 20_000_000,
  parameter int DWELL_CYC   = 2_000_000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tone_n,
  output logic [DIVW-1:0] div_o,
  output logic            done_o,
  output logic            done_grp_o
);
  localparam int POS_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int GAP_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int DWL_W = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
  localparam int CODE_W = DIGITS * DIGW;

  function automatic logic [DIGW-1:0] digit_at(input track_e trk, input logic [POS_W-1:0] p);
    logic [CODE_W-1:0] code;
    code = (trk == TRK_GRP) ? GRP_CODE : IND_CODE;
    return code[(DIGITS - 1 - int'(p)) * DIGW +: DIGW];
  endfunction

  function automatic logic [DIVW-1:0] div_of(input logic [DIGW-1:0] d);
    int v;
    v = DIV_BASE - int'(d) * DIV_STEP;
    return v[DIVW-1:0];
  endfunction

  logic [POS_W-1:0] pos_q, pos_n;
  track_e           trk_q, trk_n;
  logic             in_q, in_n, grun_q, grun_n, done_n, dgrp_n;
  logic [GAP_W-1:0] gcnt_q, gcnt_n;
  logic [DWL_W-1:0] dcnt_q, dcnt_n;

  always_comb begin
    pos_n  = pos_q;
    trk_n  = trk_q;
    in_n   = in_q;
    grun_n = grun_q;
    gcnt_n = gcnt_q;
    dcnt_n = dcnt_q;
    done_n = 1'b0;
    dgrp_n = done_grp_o;
    if (!in_q && !tone_n) begin
      in_n   = 1'b1;
      grun_n = 1'b0;
    end else if (in_q && tone_n) begin
      in_n = 1'b0;
      if (pos_q == POS_W'(DIGITS - 1)) begin
        done_n = 1'b1;
        dgrp_n = (trk_q == TRK_GRP);
        pos_n  = '0;
        trk_n  = TRK_IND;
        dcnt_n = '0;
        grun_n = 1'b0;
      end else begin
        pos_n  = pos_q + 1'b1;
        grun_n = 1'b1;
        gcnt_n = '0;
      end
    end else if (grun_q && !in_q) begin
      if (gcnt_q == GAP_W'(TIMEOUT_CYC - 1)) begin
        pos_n  = '0;
        trk_n  = TRK_IND;
        grun_n = 1'b0;
        dcnt_n = '0;
      end else begin
        gcnt_n = gcnt_q + 1'b1;
      end
    end else if (pos_q == '0 && !in_q) begin
      if (dcnt_q == DWL_W'(DWELL_CYC - 1)) begin
        dcnt_n = '0;
        trk_n  = (trk_q == TRK_IND) ? TRK_GRP : TRK_IND;
      end else begin
        dcnt_n = dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      trk_q      <= TRK_IND;
      in_q       <= 1'b0;
      grun_q     <= 1'b0;
      gcnt_q     <= '0;
      dcnt_q     <= '0;
      done_o     <= 1'b0;
      done_grp_o <= 1'b0;
      div_o      <= div_of(digit_at(TRK_IND, '0));
    end else begin
      pos_q      <= pos_n;
      trk_q      <= trk_n;
      in_q       <= in_n;
      grun_q     <= grun_n;
      gcnt_q     <= gcnt_n;
      dcnt_q     <= dcnt_n;
      done_o     <= done_n;
      done_grp_o <= dgrp_n;
      div_o      <= div_of(digit_at(trk_n, pos_n));
    end
  end

  AST_TIMEOUT_HOME: assert property (@(posedge clk) disable iff (rst)
    (grun_q && !in_q && tone_n && gcnt_q == GAP_W'(TIMEOUT_CYC - 1)) |=> (pos_q == '0 && trk_q == TRK_IND)); // R8
  AST_DONE_HOME: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pos_q == '0)); // R3
  AST_TONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_q && !tone_n) |=> ($stable(pos_q) && $stable(trk_q))); // R9
endmodule

// File: rtl/selcall_alarm.sv
module selcall_alarm #(
  parameter int ALARM_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic done,
  input  logic done_grp,
  input  logic call_reset,
  input  logic test_i,
  output logic notify_o,
  output logic relay_o,
  output logic alarm_o,
  output logic all_call_o
);
  localparam int AW = (ALARM_TICKS > 1) ? $clog2(ALARM_TICKS) : 1;

  logic          lat_q, lat_n, rel_q, rel_n, grp_n;
  logic [AW-1:0] cnt_q, cnt_n;

  always_comb begin
    lat_n = lat_q;
    rel_n = rel_q;
    grp_n = all_call_o;
    cnt_n = cnt_q;
    if (done) begin
      lat_n = 1'b1;
      rel_n = 1'b1;
      grp_n = done_grp;
      cnt_n = '0;
    end else if (call_reset) begin
      lat_n = 1'b0;
      rel_n = 1'b0;
      grp_n = 1'b0;
    end else if (lat_q && !all_call_o && tick) begin
      if (cnt_q == AW'(ALARM_TICKS - 1)) lat_n = 1'b0;
      else cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q      <= 1'b0;
      rel_q      <= 1'b0;
      cnt_q      <= '0;
      notify_o   <= 1'b0;
      relay_o    <= 1'b0;
      alarm_o    <= 1'b0;
      all_call_o <= 1'b0;
    end else begin
      lat_q      <= lat_n;
      rel_q      <= rel_n;
      cnt_q      <= cnt_n;
      notify_o   <= done;
      relay_o    <= rel_n | test_i;
      alarm_o    <= lat_n | test_i;
      all_call_o <= grp_n;
    end
  end

  AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (rst)
    notify_o |=> !notify_o); // R3
  AST_NOTIFY_RELAY: assert property (@(posedge clk) disable iff (rst)
    notify_o |-> (relay_o && alarm_o)); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (call_reset && !done && !test_i) |=> (!relay_o && !alarm_o && !all_call_o)); // R6
  AST_TEST_FORCES: assert property (@(posedge clk) disable iff (rst)
    test_i |=> (relay_o && alarm_o)); // R7
  AST_GROUP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (all_call_o && lat_q && !call_reset) |=> lat_q); // R5
endmodule

// File: rtl/selcall_decoder.sv
module selcall_decoder #(
  parameter int DIGITS      = 5,
  parameter int DIGW        = 4,
  parameter int DIVW        = 8,
  parameter logic [DIGITS*DIGW-1:0] IND_CODE = 20'h27183,
  parameter logic [DIGITS*DIGW-1:0] GRP_CODE = 20'h99999,
  parameter int DIV_BASE    = 200,
  parameter int DIV_STEP    = 7,
  parameter int TIMEOUT_CYC = 20_000_000,
  parameter int DWELL_CYC   = 2_000_000,
  parameter int TICK_CYC    = 200_000_000,
  parameter int ALARM_TICKS = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tone_n,
  input  logic            call_reset,
  input  logic            test_i,
  output logic [DIVW-1:0] div_o,
  output logic            notify_o,
  output logic            relay_o,
  output logic            alarm_o,
  output logic            all_call_o
);
  logic tick, done, done_grp;

  selcall_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  selcall_seq #(
    .DIGITS(DIGITS), .DIGW(DIGW), .DIVW(DIVW),
    .IND_CODE(IND_CODE), .GRP_CODE(GRP_CODE),
    .DIV_BASE(DIV_BASE), .DIV_STEP(DIV_STEP),
    .TIMEOUT_CYC(TIMEOUT_CYC), .DWELL_CYC(DWELL_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .tone_n(tone_n),
    .div_o(div_o), .done_o(done), .done_grp_o(done_grp)
  );

  selcall_alarm #(.ALARM_TICKS(ALARM_TICKS)) u_alarm (
    .clk(clk), .rst(rst), .tick(tick), .done(done), .done_grp(done_grp),
    .call_reset(call_reset), .test_i(test_i),
    .notify_o(notify_o), .relay_o(relay_o), .alarm_o(alarm_o),
    .all_call_o(all_call_o)
  );
endmodule

// File: tb/selcall_decoder_test.sv
module selcall_decoder_test;
  localparam int T_TICK = 20, T_ALARM = 10, T_TMO = 30, T_DWELL = 8;
  localparam int IND = 'h27183, GRP = 'h99999;

  logic clk = 1'b0, rst = 1'b1, tone_n = 1'b1, call_reset = 1'b0, test_i = 1'b0;
  logic [7:0] div_o;
  logic notify_o, relay_o, alarm_o, all_call_o;
  int checks = 0, errors = 0, notes = 0;

  always #2.5 clk = ~clk;

  selcall_decoder #(
    .TIMEOUT_CYC(T_TMO), .DWELL_CYC(T_DWELL), .TICK_CYC(T_TICK), .ALARM_TICKS(T_ALARM)
  ) uut (
    .clk(clk), .rst(rst), .tone_n(tone_n), .call_reset(call_reset), .test_i(test_i),
    .div_o(div_o), .notify_o(notify_o), .relay_o(relay_o), .alarm_o(alarm_o),
    .all_call_o(all_call_o)
  );

  function automatic int dig(int trk, int p);
    int code;
    code = trk ? GRP : IND;
    return (code >> ((4 - p) * 4)) & 15;
  endfunction
  function automatic int dv(int d);
    return (200 - d * 7) & 255;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pos, m_trk, m_in, m_grun, m_gcnt, m_dcnt, m_done, m_dgrp;
  int t_cnt, m_tick, a_lat, a_rel, a_grp, a_cnt;
  int e_div, e_not, e_rel, e_alm, e_all;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_trk = 0; m_in = 0; m_grun = 0; m_gcnt = 0; m_dcnt = 0;
      m_done = 0; m_dgrp = 0; t_cnt = 0; m_tick = 0;
      a_lat = 0; a_rel = 0; a_grp = 0; a_cnt = 0;
      e_div = dv(dig(0, 0)); e_not = 0; e_rel = 0; e_alm = 0; e_all = 0;
    end else begin
      // alarm stage sees last cycle's completion and tick
      if (m_done != 0) begin
        a_lat = 1; a_rel = 1; a_grp = m_dgrp; a_cnt = 0;
      end else if (call_reset) begin
        a_lat = 0; a_rel = 0; a_grp = 0;
      end else if (a_lat != 0 && a_grp == 0 && m_tick != 0) begin
        if (a_cnt == T_ALARM - 1) a_lat = 0;
        else a_cnt++;
      end
      e_not = m_done;
      e_rel = a_rel | int'(test_i);
      e_alm = a_lat | int'(test_i);
      e_all = a_grp;
      // slow tick
      if (t_cnt == T_TICK - 1) begin t_cnt = 0; m_tick = 1; end
      else begin t_cnt++; m_tick = 0; end
      // digit tracking
      m_done = 0;
      if (m_in == 0 && tone_n == 1'b0) begin
        m_in = 1; m_grun = 0;
      end else if (m_in != 0 && tone_n == 1'b1) begin
        m_in = 0;
        if (m_pos == 4) begin
          m_done = 1; m_dgrp = m_trk; m_pos = 0; m_trk = 0; m_dcnt = 0; m_grun = 0;
        end else begin
          m_pos++; m_grun = 1; m_gcnt = 0;
        end
      end else if (m_grun != 0) begin
        if (m_gcnt == T_TMO - 1) begin
          m_pos = 0; m_trk = 0; m_grun = 0; m_dcnt = 0;
        end else m_gcnt++;
      end else if (m_pos == 0 && m_in == 0) begin
        if (m_dcnt == T_DWELL - 1) begin m_dcnt = 0; m_trk = 1 - m_trk; end
        else m_dcnt++;
      end
      e_div = dv(dig(m_trk, m_pos));
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2/R9/R10 div_o", int'(div_o), e_div);
      chk("R3 notify_o", int'(notify_o), e_not);
      chk("R6/R7 relay_o", int'(relay_o), e_rel);
      chk("R4/R5 alarm_o", int'(alarm_o), e_alm);
      chk("R5 all_call_o", int'(all_call_o), e_all);
      if (notify_o) notes++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_div(int v);
    for (int i = 0; i < 100 && int'(div_o) != v; i++) step(1);
  endtask

  task automatic tone(int last_collide);
    tone_n = 1'b0; step(3);
    tone_n = 1'b1; step(1);
    if (last_collide != 0) begin call_reset = 1'b1; step(1); call_reset = 1'b0; end
    step(3);
  endtask

  task automatic send_call(int trk, int collide);
    wait_div(dv(dig(trk, 0)));
    for (int k = 0; k < 5; k++) tone((k == 4) ? collide : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 div_o reset", int'(div_o), dv(2));
    chk("R1 alarm_o reset", int'(alarm_o), 0);
    chk("R1 relay_o reset", int'(relay_o), 0);

    // R9 alternation while idle
    begin
      int seen_i = 0, seen_g = 0;
      for (int i = 0; i < 24; i++) begin
        if (int'(div_o) == dv(2)) seen_i = 1;
        if (int'(div_o) == dv(9)) seen_g = 1;
        step(1);
      end
      chk("R9 both first dividers seen", seen_i + seen_g, 2);
    end

    // R2/R10 first step of an individual call
    wait_div(dv(2));
    tone_n = 1'b0; step(3); tone_n = 1'b1; step(1);
    chk("R2 R10 div after first tone", int'(div_o), 151);
    step(3);
    for (int k = 1; k < 5; k++) tone(0);
    chk("R3 one notify pulse", notes, 1);
    chk("R3 relay after call", int'(relay_o), 1);
    chk("R3 back at digit 0", (int'(div_o) == dv(2) || int'(div_o) == dv(9)) ? 1 : 0, 1);
    step(T_TICK * T_ALARM + 60);
    chk("R4 alarm expired", int'(alarm_o), 0);
    chk("R4 relay held", int'(relay_o), 1);
    call_reset = 1'b1; step(1); call_reset = 1'b0; step(1);
    chk("R6 relay cleared", int'(relay_o), 0);

    // R5 group call
    send_call(1, 0);
    step(T_TICK * T_ALARM + 60);
    chk("R5 group alarm held", int'(alarm_o), 1);
    chk("R5 all_call flag", int'(all_call_o), 1);

    // R6 completion and reset in the same cycle
    send_call(0, 1);
    chk("R6 completion wins relay", int'(relay_o), 1);
    chk("R6 completion wins alarm", int'(alarm_o), 1);
    chk("R6 all_call follows new call", int'(all_call_o), 0);
    call_reset = 1'b1; step(1); call_reset = 1'b0; step(1);

    // R8 timeout between digits
    notes = 0;
    wait_div(dv(2));
    tone(0); tone(0);
    step(T_TMO + 5);
    chk("R8 timeout to digit 0", (int'(div_o) == dv(2) || int'(div_o) == dv(9)) ? 1 : 0, 1);
    tone(0); tone(0); tone(0);
    step(T_TMO + 5);
    chk("R8 no acceptance after timeout", notes, 0);

    // R7 self-test
    test_i = 1'b1; step(4);
    chk("R7 alarm forced", int'(alarm_o), 1);
    chk("R7 relay forced", int'(relay_o), 1);
    chk("R7 no notify", notes, 0);
    test_i = 1'b0; step(3);
    chk("R7 released", int'(alarm_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule